// File: doc/BRIEF.md
# Transmit Descriptor Fetch Scheduler

This block decides when the transmit path should read more descriptors from a circular ring in host memory and how many each read should carry. Software advances a tail pointer to hand descriptors to hardware; the block keeps its own fetch pointer. The descriptors from the fetch pointer up to, but not including, the tail are the ones hardware may read. All other ring slots belong to software.

A fetch is started immediately when the on-chip descriptor buffer has run dry. A fetch is also started early, as a prefetch, when buffer occupancy falls under a programmable level and enough descriptors are waiting in host memory. Each fetch is sized to fit the buffer's free space, the descriptors available and the distance to the ring end. Its end is then pulled back to a cache-line boundary (4 descriptors per line) whenever one lies inside it. A fetch that starts off a line boundary therefore realigns every fetch after it.

The memory side sees a request that is held with its start index and count until a one-cycle done strobe. Only one request is outstanding at a time.

Top module: `txd_fetch_sched`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `fetch_req` is 0 and `fetch_ptr` is 0. The sampled tail is also 0, so no descriptors are available.
- R2: With no request outstanding and `buf_occ` equal to 0, a `tail_wr` strobe that makes descriptors available raises `fetch_req` on the second rising edge after the strobe is sampled. The strobe is sampled at edge 1, `fetch_req` is still 0 after edge 1, and it is 1 after edge 2.
- R3: With no request outstanding, `buf_occ` nonzero and a nonzero count possible, a prefetch is issued only when `buf_occ < pf_thresh` and the available count is at least `host_thresh`. A `host_thresh` of 0 acts as 1.
- R4: The request count is `min(available, BUF_DEPTH - buf_occ, ring_len - fetch_ptr)`, with the end rounding of R5 applied. Available means `(tail - fetch_ptr) mod ring_len`. A request with count 0 is never issued.
- R5: If a multiple of 4 lies strictly after the start index and at or before start plus the R4 limit, the fetch ends at the largest such multiple. Otherwise it takes the whole limit.
- R6: A request never covers the slot at the tail or any slot after it: the count never exceeds the available count.
- R7: `fetch_req`, `fetch_start` and `fetch_cnt` stay constant until `fetch_done` is seen while `fetch_req` is high. No second request overlaps the first.
- R8: At the edge where `fetch_done` is seen with `fetch_req` high, `fetch_req` falls and `fetch_ptr` becomes `(fetch_start + fetch_cnt) mod ring_len`.
- R9: A `fetch_done` strobe while `fetch_req` is low changes neither `fetch_ptr` nor `fetch_req`.
- R10: Index arithmetic wraps modulo `ring_len`. A fetch never runs past slot `ring_len - 1`; it stops there and the next fetch starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tail_wr | input | 1 | Host tail-pointer write strobe |
| tail_val | input | RING_W | New tail index |
| ring_len | input | RING_W+1 | Ring size in descriptors (2 .. 2^RING_W) |
| pf_thresh | input | OCC_W | Occupancy level below which prefetch is allowed |
| host_thresh | input | RING_W+1 | Minimum available descriptors for a prefetch (0 means 1) |
| buf_occ | input | OCC_W | Current on-chip descriptor buffer occupancy |
| fetch_done | input | 1 | Memory side finished the outstanding fetch |
| fetch_req | output | 1 | Fetch request, held until done |
| fetch_start | output | RING_W | First ring index of the fetch |
| fetch_cnt | output | OCC_W | Number of descriptors in the fetch |
| fetch_ptr | output | RING_W | Next ring index hardware will fetch |

## Verification
The assertions take several things for granted about the inputs:
- `ring_len` stays fixed between resets.
- `tail_val` is below `ring_len`, and the tail advances by no more than the software-owned slots, so the available count only grows while a request is outstanding.
- `buf_occ` never exceeds the buffer depth.

The stimulus respects each of these. It changes the ring length only under reset and draws each tail step from the free slots the bench's ring model computes. It also holds occupancy at full depth while the tail and done strobes take effect, so that every decision is made on one consistent set of inputs.

// File: rtl/txd_fetch_pkg.sv
package txd_fetch_pkg;
  // one cache line carries this many descriptors (64-byte line, 16-byte descriptor)
  localparam int unsigned DESC_PER_LINE = 4;
endpackage

// File: rtl/txd_ring_window.sv
// Hardware-owned window of the ring: slots from the fetch pointer up to the tail.
module txd_ring_window #(
  parameter int RING_W = 8,
  localparam int W = RING_W + 1
) (
  input  logic [RING_W-1:0] head,
  input  logic [RING_W-1:0] tail,
  input  logic [W-1:0]      ring_len,
  output logic [W-1:0]      avail,
  output logic [W-1:0]      to_wrap
);
  logic [W-1:0] h_x, t_x;
  assign h_x = {1'b0, head};
  assign t_x = {1'b0, tail};

  always_comb begin
    if (t_x >= h_x) avail = t_x - h_x;
    else            avail = t_x + ring_len - h_x;
    to_wrap = ring_len - h_x;
  end
endmodule

// File: rtl/txd_fetch_sizer.sv
// Picks the descriptor count of the next fetch.
module txd_fetch_sizer #(
  parameter int RING_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int LINE_DESC = txd_fetch_pkg::DESC_PER_LINE,
  localparam int W     = RING_W + 1,
  localparam int OCC_W = $clog2(BUF_DEPTH + 1),
  localparam int LG    = $clog2(LINE_DESC)
) (
  input  logic [RING_W-1:0] start,
  input  logic [W-1:0]      avail,
  input  logic [W-1:0]      to_wrap,
  input  logic [OCC_W-1:0]  occ,
  output logic [OCC_W-1:0]  cnt
);
  logic [W-1:0] free_sp, lim_a, limit;

  always_comb begin
    if (W'(occ) >= W'(BUF_DEPTH)) free_sp = '0;
    else                          free_sp = W'(BUF_DEPTH) - W'(occ);
    lim_a = (avail < to_wrap) ? avail : to_wrap;
    limit = (lim_a < free_sp) ? lim_a : free_sp;
  end

  generate
    if (LG == 0) begin : g_no_round
      assign cnt = OCC_W'(limit);
    end else begin : g_line_round
      logic [W:0] end_x, end_dn, start_x;
      always_comb begin
        start_x = {2'b00, start};
        end_x   = start_x + {1'b0, limit};
        end_dn  = {end_x[W:LG], {LG{1'b0}}};
        if (end_dn > start_x) cnt = OCC_W'(end_dn - start_x);
        else                  cnt = OCC_W'(limit);
      end
    end
  endgenerate
endmodule

// File: rtl/txd_fetch_ctrl.sv
// Tail capture, fetch pointer, issue decision and request handshake.
module txd_fetch_ctrl #(
  parameter int RING_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int LINE_DESC = txd_fetch_pkg::DESC_PER_LINE,
  localparam int W     = RING_W + 1,
  localparam int OCC_W = $clog2(BUF_DEPTH + 1),
  localparam int LG    = $clog2(LINE_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tail_wr,
  input  logic [RING_W-1:0] tail_val,
  input  logic [W-1:0]      ring_len,
  input  logic [OCC_W-1:0]  pf_thresh,
  input  logic [W-1:0]      host_thresh,
  input  logic [OCC_W-1:0]  buf_occ,
  input  logic              fetch_done,
  input  logic [W-1:0]      avail,
  input  logic [OCC_W-1:0]  cnt_next,
  output logic [RING_W-1:0] tail_q,
  output logic [RING_W-1:0] fptr_q,
  output logic              req_q,
  output logic [RING_W-1:0] start_q,
  output logic [OCC_W-1:0]  cnt_q
);
  logic [W-1:0] host_min, adv;
  logic         want, issue;

  always_comb begin
    host_min = (host_thresh == '0) ? W'(1) : host_thresh;
    want  = (buf_occ == '0) || ((buf_occ < pf_thresh) && (avail >= host_min));
    issue = !req_q && (cnt_next != '0) && want;
    adv   = {1'b0, fptr_q} + W'(cnt_q);
    if (adv >= ring_len) adv = adv - ring_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q  <= '0;
      fptr_q  <= '0;
      req_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (tail_wr) tail_q <= tail_val;
      if (req_q && fetch_done) begin
        req_q  <= 1'b0;
        fptr_q <= adv[RING_W-1:0];
      end else if (issue) begin
        req_q   <= 1'b1;
        start_q <= fptr_q;
        cnt_q   <= cnt_next;
      end
    end
  end

  // R2: empty buffer with descriptors waiting leads to a request next cycle
  p_empty_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (!req_q && buf_occ == '0 && avail != '0) |=> req_q);
  // R7: request and its fields held until done
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req_q && !fetch_done) |=> (req_q && $stable(start_q) && $stable(cnt_q)));
  // R6: never at or beyond the tail
  p_tail_bound_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (cnt_q != '0 && W'(cnt_q) <= avail));
  // R10: no fetch runs past the ring end
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    req_q |-> ({1'b0, start_q} + W'(cnt_q) <= ring_len));
  // R5: an unaligned end only when no line boundary lies inside the fetch
  p_line_end_r5: assert property (@(posedge clk) disable iff (rst)
    (req_q && ((W'(start_q) + W'(cnt_q)) % W'(LINE_DESC) != '0)) |->
    ((W'(start_q) + W'(cnt_q)) / W'(LINE_DESC) == W'(start_q) / W'(LINE_DESC)));
  // R8: pointer advance on done
  p_ptr_adv_r8: assert property (@(posedge clk) disable iff (rst)
    (req_q && fetch_done) |=> (!req_q &&
      W'(fptr_q) == (W'($past(start_q)) + W'($past(cnt_q))) % ring_len));
  // R9: stray done is ignored
  p_stray_done_r9: assert property (@(posedge clk) disable iff (rst)
    (!req_q && fetch_done) |=> $stable(fptr_q));
endmodule

// File: rtl/txd_fetch_sched.sv
module txd_fetch_sched #(
  parameter int RING_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int LINE_DESC = txd_fetch_pkg::DESC_PER_LINE,
  localparam int W     = RING_W + 1,
  localparam int OCC_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tail_wr,
  input  logic [RING_W-1:0] tail_val,
  input  logic [W-1:0]      ring_len,
  input  logic [OCC_W-1:0]  pf_thresh,
  input  logic [W-1:0]      host_thresh,
  input  logic [OCC_W-1:0]  buf_occ,
  input  logic              fetch_done,
  output logic              fetch_req,
  output logic [RING_W-1:0] fetch_start,
  output logic [OCC_W-1:0]  fetch_cnt,
  output logic [RING_W-1:0] fetch_ptr
);
  logic [RING_W-1:0] tail_q, fptr_q;
  logic [W-1:0]      avail, to_wrap;
  logic [OCC_W-1:0]  cnt_next;

  txd_ring_window #(.RING_W(RING_W)) u_win (
    .head(fptr_q), .tail(tail_q), .ring_len(ring_len),
    .avail(avail), .to_wrap(to_wrap));

  txd_fetch_sizer #(.RING_W(RING_W), .BUF_DEPTH(BUF_DEPTH), .LINE_DESC(LINE_DESC)) u_size (
    .start(fptr_q), .avail(avail), .to_wrap(to_wrap), .occ(buf_occ), .cnt(cnt_next));

  txd_fetch_ctrl #(.RING_W(RING_W), .BUF_DEPTH(BUF_DEPTH), .LINE_DESC(LINE_DESC)) u_ctrl (
    .clk(clk), .rst(rst), .tail_wr(tail_wr), .tail_val(tail_val),
    .ring_len(ring_len), .pf_thresh(pf_thresh), .host_thresh(host_thresh),
    .buf_occ(buf_occ), .fetch_done(fetch_done), .avail(avail), .cnt_next(cnt_next),
    .tail_q(tail_q), .fptr_q(fptr_q), .req_q(fetch_req),
    .start_q(fetch_start), .cnt_q(fetch_cnt));

  assign fetch_ptr = fptr_q;

  // R4: count never exceeds the buffer depth
  p_buf_room_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> (fetch_cnt <= OCC_W'(BUF_DEPTH)));
endmodule

// File: tb/sim_txd_fetch_sched.sv
`timescale 1ns/1ps
module sim_txd_fetch_sched;
  localparam int RING_W = 8;
  localparam int DEPTH  = 16;
  localparam int W      = RING_W + 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1, tail_wr = 0, fetch_done = 0;
  logic [RING_W-1:0] tail_val = '0;
  logic [W-1:0]      ring_len = W'(64), host_thresh = '0;
  logic [OCC_W-1:0]  pf_thresh = '0, buf_occ = OCC_W'(DEPTH);
  logic              fetch_req;
  logic [RING_W-1:0] fetch_start, fetch_ptr;
  logic [OCC_W-1:0]  fetch_cnt;

  int errs = 0, checks = 0, len = 64, m_ptr = 0, m_tail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txd_fetch_sched #(.RING_W(RING_W), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .tail_wr(tail_wr), .tail_val(tail_val),
    .ring_len(ring_len), .pf_thresh(pf_thresh), .host_thresh(host_thresh),
    .buf_occ(buf_occ), .fetch_done(fetch_done), .fetch_req(fetch_req),
    .fetch_start(fetch_start), .fetch_cnt(fetch_cnt), .fetch_ptr(fetch_ptr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_avail(int p, int t);
    return (t - p + len) % len;
  endfunction

  // R4 limit and R5 line rounding, from the requirement text
  function automatic int f_cnt(int p, int t, int occ);
    int lim, e, edn;
    lim = f_avail(p, t);
    if (DEPTH - occ < lim) lim = DEPTH - occ;
    if (len - p < lim) lim = len - p;
    e = p + lim;
    edn = (e / 4) * 4;
    return (edn > p) ? edn - p : lim;
  endfunction

  function automatic bit f_want(int p, int t, int occ, int pf, int ht);
    int hm;
    hm = (ht == 0) ? 1 : ht;
    if (f_cnt(p, t, occ) == 0) return 0;
    return (occ == 0) || (occ < pf && f_avail(p, t) >= hm);
  endfunction

  task automatic do_reset(input int l);
    @(negedge clk);
    rst = 1; len = l; ring_len = W'(l); buf_occ = OCC_W'(DEPTH);
    tail_wr = 0; fetch_done = 0;
    repeat (3) @(negedge clk);
    rst = 0; m_ptr = 0; m_tail = 0;
  endtask

  // one round: retire any request, move tail, then set occupancy and thresholds
  task automatic round(input int adv, input int occ, input int pf, input int ht);
    @(negedge clk);
    if (fetch_req) m_ptr = (int'(fetch_start) + int'(fetch_cnt)) % len;
    fetch_done = 1;            // R9 when no request is pending
    buf_occ = OCC_W'(DEPTH);
    m_tail = (m_tail + adv) % len;
    tail_wr = 1; tail_val = RING_W'(m_tail);
    @(negedge clk);
    fetch_done = 0; tail_wr = 0;
    buf_occ = OCC_W'(occ); pf_thresh = OCC_W'(pf); host_thresh = W'(ht);
    @(negedge clk);
    chk(int'(fetch_ptr) == m_ptr, "R8 R9 R10 fetch_ptr", int'(fetch_ptr), m_ptr);
    if (f_want(m_ptr, m_tail, occ, pf, ht)) begin
      chk(fetch_req, (occ == 0) ? "R2 request" : "R3 prefetch", int'(fetch_req), 1);
      chk(int'(fetch_start) == m_ptr, "R7 fetch_start", int'(fetch_start), m_ptr);
      chk(int'(fetch_cnt) == f_cnt(m_ptr, m_tail, occ), "R4 R5 R6 fetch_cnt",
          int'(fetch_cnt), f_cnt(m_ptr, m_tail, occ));
    end else begin
      chk(!fetch_req, "R3 no prefetch", int'(fetch_req), 0);
    end
  endtask

  initial begin
    int lens[4] = '{64, 13, 7, 100};
    void'($urandom(32'h5eed_0042));
    do_reset(64);
    // R1 reset state
    chk(!fetch_req, "R1 fetch_req", int'(fetch_req), 0);
    chk(fetch_ptr == 0, "R1 fetch_ptr", int'(fetch_ptr), 0);
    // R2 timing with empty buffer
    buf_occ = '0;
    @(negedge clk);
    chk(!fetch_req, "R1 nothing available", int'(fetch_req), 0);
    tail_wr = 1; tail_val = 8'd6; m_tail = 6;
    @(negedge clk);
    tail_wr = 0;
    chk(!fetch_req, "R2 not after first edge", int'(fetch_req), 0);
    @(negedge clk);
    chk(fetch_req, "R2 after second edge", int'(fetch_req), 1);
    chk(fetch_cnt == 4, "R5 rounded to line", int'(fetch_cnt), 4);
    // R7 hold without done
    repeat (3) @(negedge clk);
    chk(fetch_req && fetch_start == 0 && fetch_cnt == 4, "R7 held",
        int'(fetch_cnt), 4);
    round(0, 0, 0, 0);
    chk(fetch_cnt == 2 && fetch_start == 4, "R5 tail-limited tail end",
        int'(fetch_cnt), 2);
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(lens[ph]);
      for (int i = 0; i < 150; i++) begin
        int np, room, adv;
        np = m_ptr;
        if (fetch_req) np = (int'(fetch_start) + int'(fetch_cnt)) % len;
        room = len - 1 - f_avail(np, m_tail);
        adv = (room > 0) ? int'($urandom % (room + 1)) : 0;
        round(adv, int'($urandom % (DEPTH + 1)), int'($urandom % (DEPTH + 1)),
              int'($urandom % 6));
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      finished = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule